// File: doc/BRIEF.md
# DMA Control and Status Register File

This block is the software-facing register file for a DMA with two directions: stream-to-memory (S2M) and memory-to-stream (M2S). A host reaches it through an AXI-Lite slave port. The block turns the stored words into control signals for each engine: a start pulse, a stop pulse, a circular flag, a beat-size code, a burst length, a byte count and a base address. In the other direction, each engine sends a one-cycle done pulse. The block records it in a status word that software polls and clears.

The write address and the write data are captured independently, so a master may present them in either order or together. Software starts or stops an engine by writing a 1 to the start or stop bit. It never writes the bit back to 0, because the block clears it on the next cycle. A done flag stays set until software writes a 0 to it, so a slow poller cannot miss a completion.

Top module: `dma_regfile`

## Requirements
- R1: After an active-low asynchronous reset, every register reads 0 and every decoded output is 0. AWREADY, WREADY and ARREADY are high, and BVALID and RVALID are low.
- R2: The write address and write data are accepted in any order, including together. A register is written only once both have been accepted. AWREADY stays low while an accepted address waits for its data, and WREADY stays low while accepted data waits for its address.
- R3: Each committed write raises BVALID with BRESP = 2'b00. BVALID stays high until a cycle with BREADY high.
- R4: On a read-address handshake, the addressed register is returned on RDATA with RVALID high and RRESP = 2'b00. RVALID and RDATA hold until RREADY, and ARREADY is low while RVALID is high.
- R5: The register index is taken from address bits [ADDR_WIDTH-1:2]:
  - 0x00: S2M control
  - 0x04: S2M byte count
  - 0x08: S2M base address
  - 0x0C: M2S control
  - 0x10: M2S byte count
  - 0x14: M2S base address
  - 0x18: status
- R6: Both control words share one field layout:
  - bit 0: start
  - bit 1: stop
  - bit 2: circular
  - bits [5:3]: beat-size code
  - bits [13:6]: burst length

  Each engine's outputs show its control fields, byte count and base address.
- R7: The start and stop bits are high for exactly one cycle after a write that sets them. They then read back as 0, while the other control bits keep their written values.
- R8: Status bit 0 is set by a pulse on s2m_done, and status bit 1 by a pulse on m2s_done. Each bit stays set until software writes 0 to that bit position.
- R9: When a done pulse coincides with the commit of a status write, that status bit is set and the written value for it is discarded. The other status bit takes the written value.
- R10: Writes to offsets above 0x18 complete with OKAY and change nothing. Reads from offsets above 0x18 return 0.
- R11: WSTRB is ignored, so every write replaces the whole 32-bit word. Status bits [31:2] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | ADDR_WIDTH | Write byte address |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte strobes (ignored) |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response, always OKAY |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| araddr | input | ADDR_WIDTH | Read byte address |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response, always OKAY |
| s2m_start | output | 1 | S2M start pulse |
| s2m_stop | output | 1 | S2M stop pulse |
| s2m_circular | output | 1 | S2M circular mode |
| s2m_size | output | 3 | S2M beat-size code |
| s2m_len | output | 8 | S2M burst length |
| s2m_count | output | 32 | S2M byte count |
| s2m_base | output | 32 | S2M base address |
| s2m_done | input | 1 | S2M completion pulse |
| m2s_start | output | 1 | M2S start pulse |
| m2s_stop | output | 1 | M2S stop pulse |
| m2s_circular | output | 1 | M2S circular mode |
| m2s_size | output | 3 | M2S beat-size code |
| m2s_len | output | 8 | M2S burst length |
| m2s_count | output | 32 | M2S byte count |
| m2s_base | output | 32 | M2S base address |
| m2s_done | input | 1 | M2S completion pulse |

## Verification
The assertions check the handshake rules on every cycle:
- Accepting an address closes AWREADY.
- An accepted read produces RVALID.
- BVALID, RVALID and RDATA hold under backpressure.
- Start and stop stay one cycle wide.
- A done pulse always lands in the status word, even over a simultaneous software write.
- A status bit never drops without a software write.

Only the bench's scenarios can show the rest:
- The register map and field layout.
- Commit in each arrival order.
- Read-back after the self-clear.
- The effect of the written value on the status bit that no pulse touches.
- The silent discard of writes to offsets above the map.

// File: rtl/dma_regfile.sv
module dma_regfile #(
  parameter int ADDR_WIDTH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  awvalid,
  output logic                  awready,
  input  logic [ADDR_WIDTH-1:0] awaddr,
  input  logic                  wvalid,
  output logic                  wready,
  input  logic [31:0]           wdata,
  input  logic [3:0]            wstrb,
  output logic                  bvalid,
  input  logic                  bready,
  output logic [1:0]            bresp,
  input  logic                  arvalid,
  output logic                  arready,
  input  logic [ADDR_WIDTH-1:0] araddr,
  output logic                  rvalid,
  input  logic                  rready,
  output logic [31:0]           rdata,
  output logic [1:0]            rresp,
  output logic                  s2m_start,
  output logic                  s2m_stop,
  output logic                  s2m_circular,
  output logic [2:0]            s2m_size,
  output logic [7:0]            s2m_len,
  output logic [31:0]           s2m_count,
  output logic [31:0]           s2m_base,
  input  logic                  s2m_done,
  output logic                  m2s_start,
  output logic                  m2s_stop,
  output logic                  m2s_circular,
  output logic [2:0]            m2s_size,
  output logic [7:0]            m2s_len,
  output logic [31:0]           m2s_count,
  output logic [31:0]           m2s_base,
  input  logic                  m2s_done
);
  localparam int IDX_W    = ADDR_WIDTH - 2;
  localparam int NCFG     = 6;
  localparam int S2M_CTRL = 0;
  localparam int M2S_CTRL = 3;
  localparam logic [IDX_W-1:0] STAT_IDX = IDX_W'(NCFG);

  logic [NCFG-1:0][31:0] cfg_q;
  logic [1:0]            stat_q;
  logic                  aw_pend, w_pend, commit, stat_wr;
  logic [IDX_W-1:0]      aw_idx, ar_idx;
  logic [31:0]           w_q, rd_val;

  assign awready = !aw_pend;
  assign wready  = !w_pend;
  assign arready = !rvalid;
  assign bresp   = 2'b00;
  assign rresp   = 2'b00;
  assign commit  = aw_pend && w_pend && !bvalid;
  assign stat_wr = commit && (aw_idx == STAT_IDX);
  assign ar_idx  = araddr[ADDR_WIDTH-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_pend <= 1'b0;
      w_pend  <= 1'b0;
      aw_idx  <= '0;
      w_q     <= '0;
      bvalid  <= 1'b0;
    end else begin
      if (awvalid && awready) begin
        aw_pend <= 1'b1;
        aw_idx  <= awaddr[ADDR_WIDTH-1:2];
      end
      if (wvalid && wready) begin
        w_pend <= 1'b1;
        w_q    <= wdata;
      end
      if (commit) begin
        aw_pend <= 1'b0;
        w_pend  <= 1'b0;
        bvalid  <= 1'b1;
      end else if (bvalid && bready) begin
        bvalid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      for (int i = 0; i < NCFG; i++) begin
        if (commit && aw_idx == IDX_W'(i))
          cfg_q[i] <= w_q;
        else if (i == S2M_CTRL || i == M2S_CTRL)
          cfg_q[i][1:0] <= 2'b00;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stat_q <= '0;
    else begin
      if (s2m_done)     stat_q[0] <= 1'b1;
      else if (stat_wr) stat_q[0] <= w_q[0];
      if (m2s_done)     stat_q[1] <= 1'b1;
      else if (stat_wr) stat_q[1] <= w_q[1];
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NCFG; i++)
      if (ar_idx == IDX_W'(i)) rd_val = cfg_q[i];
    if (ar_idx == STAT_IDX) rd_val = {30'd0, stat_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (arvalid && arready) begin
      rvalid <= 1'b1;
      rdata  <= rd_val;
    end else if (rready) begin
      rvalid <= 1'b0;
    end
  end

  assign s2m_start    = cfg_q[0][0];
  assign s2m_stop     = cfg_q[0][1];
  assign s2m_circular = cfg_q[0][2];
  assign s2m_size     = cfg_q[0][5:3];
  assign s2m_len      = cfg_q[0][13:6];
  assign s2m_count    = cfg_q[1];
  assign s2m_base     = cfg_q[2];
  assign m2s_start    = cfg_q[3][0];
  assign m2s_stop     = cfg_q[3][1];
  assign m2s_circular = cfg_q[3][2];
  assign m2s_size     = cfg_q[3][5:3];
  assign m2s_len      = cfg_q[3][13:6];
  assign m2s_count    = cfg_q[4];
  assign m2s_base     = cfg_q[5];

  logic unused_ok;
  assign unused_ok = ^wstrb;
endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        awvalid,
  input logic        awready,
  input logic        bvalid,
  input logic        bready,
  input logic        arvalid,
  input logic        arready,
  input logic        rvalid,
  input logic        rready,
  input logic [31:0] rdata,
  input logic        s2m_start,
  input logic        s2m_stop,
  input logic        m2s_start,
  input logic        m2s_stop,
  input logic        s2m_done,
  input logic        m2s_done,
  input logic [1:0]  stat,
  input logic        stat_wr
);
  assert_aw_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && awready |=> !awready);
  assert_b_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid);
  assert_r_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid && arready |=> rvalid);
  assert_r_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata));
  assert_s2m_start_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s2m_start |=> !s2m_start);
  assert_s2m_stop_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s2m_stop |=> !s2m_stop);
  assert_m2s_start_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m2s_start |=> !m2s_start);
  assert_m2s_stop_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m2s_stop |=> !m2s_stop);
  assert_s2m_done_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s2m_done |=> stat[0]);
  assert_m2s_done_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    m2s_done |=> stat[1]);
  assert_s2m_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat[0] && !stat_wr |=> stat[0]);
  assert_m2s_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat[1] && !stat_wr |=> stat[1]);
  assert_done_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr && (s2m_done || m2s_done) |=> (stat[0] || !s2m_done) && (stat[1] || !m2s_done));
endmodule

bind dma_regfile dma_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .awvalid(awvalid), .awready(awready),
  .bvalid(bvalid), .bready(bready), .arvalid(arvalid), .arready(arready),
  .rvalid(rvalid), .rready(rready), .rdata(rdata),
  .s2m_start(s2m_start), .s2m_stop(s2m_stop), .m2s_start(m2s_start), .m2s_stop(m2s_stop),
  .s2m_done(s2m_done), .m2s_done(m2s_done), .stat(stat_q), .stat_wr(stat_wr)
);

// File: tb/dma_regfile_bench.sv
module dma_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
  logic [AW-1:0] awaddr = '0, araddr = '0;
  logic [31:0] wdata = '0;
  logic [3:0] wstrb = 4'h0;
  logic s2m_done = 0, m2s_done = 0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;
  logic s2m_start, s2m_stop, s2m_circular, m2s_start, m2s_stop, m2s_circular;
  logic [2:0] s2m_size, m2s_size;
  logic [7:0] s2m_len, m2s_len;
  logic [31:0] s2m_count, s2m_base, m2s_count, m2s_base;

  int n_run = 0, n_fail = 0;
  int s_start_n = 0, s_stop_n = 0, m_start_n = 0, m_stop_n = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_regfile #(.ADDR_WIDTH(AW)) u_dma_regfile (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (s2m_start) s_start_n++;
    if (s2m_stop)  s_stop_n++;
    if (m2s_start) m_start_n++;
    if (m2s_stop)  m_stop_n++;
    if (rvalid && rready) begin
      if (exp_q.size() == 0) chk("R4 unexpected read beat", rdata, 32'hx);
      else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
        chk("R4 rresp OKAY", {30'd0, rresp}, 0);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input int order,
                    input bit sp = 0, input bit mp = 0, input bit hb = 0);
    if (hb) bready = 0;
    if (order == 1) begin
      @(negedge clk); awvalid = 1; awaddr = a;
      while (!awready) @(negedge clk);
      @(negedge clk); awvalid = 0;
      chk("R2 awready low while address pending", awready, 0);
      repeat (2) @(negedge clk);
      chk("R2 no commit without data", bvalid, 0);
      wvalid = 1; wdata = d;
      while (!wready) @(negedge clk);
      @(negedge clk); wvalid = 0;
    end else if (order == 2) begin
      @(negedge clk); wvalid = 1; wdata = d;
      while (!wready) @(negedge clk);
      @(negedge clk); wvalid = 0;
      chk("R2 wready low while data pending", wready, 0);
      repeat (2) @(negedge clk);
      chk("R2 no commit without address", bvalid, 0);
      awvalid = 1; awaddr = a;
      while (!awready) @(negedge clk);
      @(negedge clk); awvalid = 0;
    end else begin
      @(negedge clk); awvalid = 1; awaddr = a; wvalid = 1; wdata = d;
      while (!(awready && wready)) @(negedge clk);
      @(negedge clk); awvalid = 0; wvalid = 0; s2m_done = sp; m2s_done = mp;
      @(negedge clk); s2m_done = 0; m2s_done = 0;
    end
    while (!bvalid) @(negedge clk);
    chk("R3 bresp OKAY", {30'd0, bresp}, 0);
    if (hb) begin
      repeat (3) @(negedge clk);
      chk("R3 bvalid held without bready", bvalid, 1);
      bready = 1;
    end
    @(negedge clk);
    chk("R3 bvalid drops after bready", bvalid, 0);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string req);
    @(negedge clk); arvalid = 1; araddr = a;
    while (!arready) @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk); arvalid = 0;
  endtask

  task automatic pulse(input bit s, input bit m);
    @(negedge clk); s2m_done = s; m2s_done = m;
    @(negedge clk); s2m_done = 0; m2s_done = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int s0, m0;
    repeat (3) @(negedge clk);
    chk("R1 ready after reset", {awready, wready, arready, bvalid, rvalid}, 5'b11100);
    chk("R1 outputs zero", s2m_count | s2m_base | m2s_count | m2s_base, 0);
    chk("R1 ctrl outputs zero", {s2m_start, s2m_circular, s2m_len, m2s_stop, m2s_size}, 0);
    rst_n = 1;
    for (int i = 0; i < 7; i++) rd(AW'(i*4), 0, "R1 register zero after reset");

    wr(8'h04, 32'h0000_0100, 1);
    wr(8'h08, 32'h8000_0000, 2);
    wr(8'h14, 32'h0000_1234, 0);
    wr(8'h10, 32'h0000_ABCD, 0, 0, 0, 1);
    chk("R5 s2m byte count", s2m_count, 32'h100);
    chk("R5 s2m base", s2m_base, 32'h8000_0000);
    chk("R5 m2s base", m2s_base, 32'h1234);
    chk("R5 m2s byte count", m2s_count, 32'hABCD);
    rd(8'h04, 32'h100, "R5 readback 0x04");
    rd(8'h08, 32'h8000_0000, "R5 readback 0x08");
    rd(8'h10, 32'hABCD, "R5 readback 0x10");
    rd(8'h14, 32'h1234, "R5 readback 0x14");

    s0 = s_start_n; m0 = m_stop_n;
    wr(8'h00, 32'h0000_0F1D, 0);
    chk("R6 s2m circular", s2m_circular, 1);
    chk("R6 s2m size", s2m_size, 3);
    chk("R6 s2m len", s2m_len, 8'h3C);
    wr(8'h0C, 32'h0000_296A, 2);
    chk("R6 m2s fields", {m2s_circular, m2s_size, m2s_len}, {1'b0, 3'd5, 8'hA5});
    repeat (3) @(negedge clk); #1;
    chk("R7 s2m start one pulse", s_start_n - s0, 1);
    chk("R7 m2s stop one pulse", m_stop_n - m0, 1);
    chk("R7 no stray stop/start", s_stop_n + m_start_n, 0);
    rd(8'h00, 32'h0000_0F1C, "R7 s2m ctrl readback self-cleared");
    rd(8'h0C, 32'h0000_2968, "R7 m2s ctrl readback self-cleared");

    pulse(1, 0);
    rd(8'h18, 32'h1, "R8 s2m done sticky");
    pulse(0, 1);
    rd(8'h18, 32'h3, "R8 both done sticky");
    wr(8'h18, 32'h2, 0);
    rd(8'h18, 32'h2, "R8 write 0 clears bit0 only");
    wr(8'h18, 32'hFFFF_FFFC, 1);
    rd(8'h18, 32'h0, "R11 status upper bits zero");

    wr(8'h18, 32'h0, 0, 1, 0);
    rd(8'h18, 32'h1, "R9 s2m done beats write of 0");
    pulse(0, 0);
    wr(8'h18, 32'h1, 0, 0, 1);
    rd(8'h18, 32'h3, "R9 m2s done with write 1 to bit0");

    wr(8'h1C, 32'hDEAD_BEEF, 0);
    wr(8'hFC, 32'hFFFF_FFFF, 1);
    rd(8'h1C, 32'h0, "R10 read above map zero");
    rd(8'hFC, 32'h0, "R10 read top offset zero");
    rd(8'h00, 32'h0000_0F1C, "R10 ctrl untouched");
    rd(8'h18, 32'h3, "R10 status untouched");
    chk("R10 base untouched", s2m_base, 32'h8000_0000);

    wstrb = 4'h1;
    wr(8'h08, 32'h1357_9BDF, 0);
    chk("R11 wstrb ignored", s2m_base, 32'h1357_9BDF);

    rready = 0;
    rd(8'h08, 32'h1357_9BDF, "R4 read under backpressure");
    repeat (2) @(negedge clk);
    chk("R4 rvalid held", rvalid, 1);
    chk("R4 arready low while rvalid", arready, 0);
    chk("R4 rdata held", rdata, 32'h1357_9BDF);
    rready = 1;

    for (int i = 0; i < 20 && exp_q.size() != 0; i++) @(negedge clk);
    chk("R4 all reads returned", exp_q.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule